// File: doc/BRIEF.md
# Delayed write tracker

This block is the target-side bookkeeping of a bus bridge that forwards single-DWORD writes as delayed transactions. An initiator write is presented on a one-cycle request port with its command, address, data word, active-low byte enables and parity. A write that is not yet known is stored in a small in-order queue and answered with a retry. The initiator is therefore never stalled, and it is expected to come back with the same write later.

The oldest stored write is offered to a forwarding engine. The engine reports back through a completion input, either with success, which marks the entry done, or with an error, which drops it. Once the head entry is done, the initiator's repeat of that write is checked against it and answered with a ready response. If the initiator asked for more than one DWORD, a disconnect is added. A done entry that the initiator never collects is removed by a discard timer, and a system error can be flagged when that happens.

Top module: `dly_wr_tracker`

## Requirements
- R1: After reset, rsp_valid, rsp_done, rsp_stop, fwd_valid, q_full, err_flag and sys_err are all 0.
- R2: Each cycle with req_valid=1 produces, on the next cycle, exactly one response with rsp_valid=1. A write whose command and address match no stored entry, arriving while the queue is not full, gets rsp_done=0 (retry) and is appended at the tail. fwd_valid and the fwd_* fields present the oldest entry while it is not yet done.
- R3: A write whose command and address equal those of any stored entry gets a retry and creates no new entry. This includes repeats that arrive before the entry has been delivered.
- R4: With DEPTH entries stored, q_full=1. A new write then gets a retry and is not stored, and q_full stays 1 until an entry leaves.
- R5: cpl_valid=1 with cpl_err=0 while the head entry is not done marks it done from the next cycle, which drops fwd_valid to 0. The head entry stays unchanged until a completion arrives.
- R6: A repeat write matches the done head entry only if command, address, all four be_n bits and the enabled data bytes agree. A match gets rsp_done=1 with rsp_stop=req_multi, and the entry is removed.
- R7: A repeat that differs from the done head entry in be_n or in any enabled data byte gets a retry, and the entry is kept.
- R8: When the head entry becomes done at clock edge E, with discard_init=L and no matching repeat arriving, the entry is removed at edge E+L+1. sys_err is 1 for the one cycle after that removal if serr_en was 1 in the expiry cycle, and 0 otherwise.
- R9: cpl_valid=1 with cpl_err=1 while the head entry is not done removes that entry, and err_flag is 1 for exactly the next cycle.
- R10: A matching repeat in the cycle the discard timer expires is completed (rsp_done=1) and no sys_err is raised. A repeat in the same cycle as the head's completion input is still answered with a retry.
- R11: be_n bit i is active low and covers data bits [8i+7:8i]. A byte whose bit is 1 is left out of the data comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Initiator write attempt this cycle |
| req_cmd | input | 4 | Bus command |
| req_addr | input | 32 | DWORD address |
| req_data | input | 32 | First data word |
| req_be_n | input | 4 | Active-low byte enables |
| req_par | input | 1 | Data parity (stored, not compared) |
| req_multi | input | 1 | Initiator intends more than one DWORD |
| cpl_valid | input | 1 | Forwarding engine finished the head entry |
| cpl_err | input | 1 | Completion ended in error |
| discard_init | input | TW | Discard timer load value |
| serr_en | input | 1 | Enable system error on discard |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_done | output | 1 | 1 = ready (transfer done), 0 = retry |
| rsp_stop | output | 1 | Disconnect alongside ready |
| fwd_valid | output | 1 | Head entry awaits forwarding |
| fwd_cmd | output | 4 | Head command |
| fwd_addr | output | 32 | Head address |
| fwd_data | output | 32 | Head data |
| fwd_be_n | output | 4 | Head byte enables |
| fwd_par | output | 1 | Head parity |
| q_full | output | 1 | Queue holds DEPTH entries |
| err_flag | output | 1 | One-cycle pulse on completion error |
| sys_err | output | 1 | One-cycle pulse on enabled discard |

## Verification
Two pairs of functions can land on one cycle. The first is discard-timer expiry and the initiator's matching repeat. The second is the forwarding engine's completion and a repeat of that same head entry. Directed steps place a repeat exactly on the expiry cycle and exactly on the completion cycle. A cycle-level bench model then judges the outcome: the first case must complete without a system error, and the second must be retried. Random traffic on a small address pool, with a small discard load, keeps producing both coincidences, along with push-and-pop in the same cycle.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be_n;
        logic              par;
    } dwt_entry_t;
endpackage

// File: rtl/dwt_match.sv
module dwt_match
    import dwt_pkg::*;
(
    input  dwt_entry_t ent,
    input  logic       vld,
    input  dwt_entry_t req,
    output logic       hit_ca,
    output logic       hit_all
);
    logic [BE_W-1:0] byte_ok;

    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        // a disabled byte (be_n high) never blocks the match
        assign byte_ok[b] = req.be_n[b] | (ent.data[8*b +: 8] == req.data[8*b +: 8]);
    end

    assign hit_ca  = vld & (ent.cmd == req.cmd) & (ent.addr == req.addr);
    assign hit_all = hit_ca & (ent.be_n == req.be_n) & (&byte_ok);
endmodule

// File: rtl/dwt_discard_timer.sv
module dwt_discard_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = arm & (cnt_q == '0);
endmodule

// File: rtl/dly_wr_tracker.sv
module dly_wr_tracker
    import dwt_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be_n,
    input  logic              req_par,
    input  logic              req_multi,
    input  logic              cpl_valid,
    input  logic              cpl_err,
    input  logic [TW-1:0]     discard_init,
    input  logic              serr_en,
    output logic              rsp_valid,
    output logic              rsp_done,
    output logic              rsp_stop,
    output logic              fwd_valid,
    output logic [CMD_W-1:0]  fwd_cmd,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data,
    output logic [BE_W-1:0]   fwd_be_n,
    output logic              fwd_par,
    output logic              q_full,
    output logic              err_flag,
    output logic              sys_err
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        dwt_entry_t [DEPTH-1:0] ent;
        logic [DEPTH-1:0]       vld;
        logic [PW-1:0]          rd;
        logic [PW-1:0]          wr;
        logic                   done;
        logic                   rsp_v;
        logic                   rsp_d;
        logic                   rsp_s;
        logic                   err;
        logic                   serr;
    } st_t;

    st_t st_d, st_q;

    dwt_entry_t       req_ent;
    logic [DEPTH-1:0] hit_ca, hit_all;
    logic             full, head_done, expire, pop_c, push_c;

    assign req_ent = '{cmd: req_cmd, addr: req_addr, data: req_data,
                       be_n: req_be_n, par: req_par};

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        dwt_match u_match (
            .ent    (st_q.ent[i]),
            .vld    (st_q.vld[i]),
            .req    (req_ent),
            .hit_ca (hit_ca[i]),
            .hit_all(hit_all[i])
        );
    end

    assign full      = &st_q.vld;
    assign head_done = st_q.done & st_q.vld[st_q.rd];

    dwt_discard_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (head_done),
        .load_val(discard_init),
        .expire  (expire)
    );

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = 1'b0;
        st_d.rsp_d = 1'b0;
        st_d.rsp_s = 1'b0;
        st_d.err   = 1'b0;
        st_d.serr  = 1'b0;
        pop_c      = 1'b0;
        push_c     = 1'b0;

        // initiator side: every attempt gets exactly one answer
        if (req_valid) begin
            st_d.rsp_v = 1'b1;
            if (head_done && hit_all[st_q.rd]) begin
                st_d.rsp_d = 1'b1;
                st_d.rsp_s = req_multi;
                pop_c      = 1'b1;
            end else if (!(|hit_ca) && !full) begin
                push_c = 1'b1;
            end
        end

        // head maintenance: a collected completion outranks expiry
        if (!pop_c) begin
            if (expire) begin
                pop_c     = 1'b1;
                st_d.serr = serr_en;
            end else if (cpl_valid && st_q.vld[st_q.rd] && !st_q.done) begin
                if (cpl_err) begin
                    pop_c    = 1'b1;
                    st_d.err = 1'b1;
                end else begin
                    st_d.done = 1'b1;
                end
            end
        end

        if (push_c) begin
            st_d.ent[st_q.wr] = req_ent;
            st_d.vld[st_q.wr] = 1'b1;
            st_d.wr           = nxt(st_q.wr);
        end
        if (pop_c) begin
            st_d.vld[st_q.rd] = 1'b0;
            st_d.rd           = nxt(st_q.rd);
            st_d.done         = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_done  = st_q.rsp_d;
    assign rsp_stop  = st_q.rsp_s;
    assign err_flag  = st_q.err;
    assign sys_err   = st_q.serr;
    assign q_full    = full;
    assign fwd_valid = st_q.vld[st_q.rd] & ~st_q.done;
    assign fwd_cmd   = st_q.ent[st_q.rd].cmd;
    assign fwd_addr  = st_q.ent[st_q.rd].addr;
    assign fwd_data  = st_q.ent[st_q.rd].data;
    assign fwd_be_n  = st_q.ent[st_q.rd].be_n;
    assign fwd_par   = st_q.ent[st_q.rd].par;
endmodule

// File: rtl/dwt_chk.sv
module dwt_chk
    import dwt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              cpl_valid,
    input logic              cpl_err,
    input logic              serr_en,
    input logic              rsp_valid,
    input logic              rsp_done,
    input logic              rsp_stop,
    input logic              fwd_valid,
    input logic [CMD_W-1:0]  fwd_cmd,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic              q_full,
    input logic              err_flag,
    input logic              sys_err
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R6
    stop_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stop |-> rsp_done && rsp_valid);

    // R8
    serr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |-> $past(serr_en));

    // R9
    err_after_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> $past(cpl_valid && cpl_err));

    // R4
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && fwd_valid && !cpl_valid |=> q_full);

    // R5
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !cpl_valid |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_cmd));
endmodule

bind dly_wr_tracker dwt_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cpl_valid (cpl_valid),
    .cpl_err   (cpl_err),
    .serr_en   (serr_en),
    .rsp_valid (rsp_valid),
    .rsp_done  (rsp_done),
    .rsp_stop  (rsp_stop),
    .fwd_valid (fwd_valid),
    .fwd_cmd   (fwd_cmd),
    .fwd_addr  (fwd_addr),
    .q_full    (q_full),
    .err_flag  (err_flag),
    .sys_err   (sys_err)
);

// File: tb/dly_wr_tracker_tb_top.sv
module dly_wr_tracker_tb_top;
    import dwt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int TW         = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_par = 1'b0, req_multi = 1'b0;
    logic [CMD_W-1:0]  req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [BE_W-1:0]   req_be_n = '0;
    logic cpl_valid = 1'b0, cpl_err = 1'b0, serr_en = 1'b0;
    logic [TW-1:0] discard_init = '0;
    logic rsp_valid, rsp_done, rsp_stop, fwd_valid, fwd_par, q_full, err_flag, sys_err;
    logic [CMD_W-1:0]  fwd_cmd;
    logic [ADDR_W-1:0] fwd_addr;
    logic [DATA_W-1:0] fwd_data;
    logic [BE_W-1:0]   fwd_be_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_wr_tracker #(.DEPTH(DEPTH), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data), .req_be_n(req_be_n),
        .req_par(req_par), .req_multi(req_multi), .cpl_valid(cpl_valid),
        .cpl_err(cpl_err), .discard_init(discard_init), .serr_en(serr_en),
        .rsp_valid(rsp_valid), .rsp_done(rsp_done), .rsp_stop(rsp_stop),
        .fwd_valid(fwd_valid), .fwd_cmd(fwd_cmd), .fwd_addr(fwd_addr),
        .fwd_data(fwd_data), .fwd_be_n(fwd_be_n), .fwd_par(fwd_par),
        .q_full(q_full), .err_flag(err_flag), .sys_err(sys_err)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // bench model of the queue, built from the requirements
    dwt_entry_t mq[DEPTH];
    int  mcnt = 0, mtmr = 0;
    bit  mdone = 1'b0;
    bit  e_rv, e_rd, e_rs, e_serr, e_err;

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // R11: enabled bytes (be_n bit 0) must agree
    function automatic bit bytes_agree(logic [31:0] a, logic [31:0] b, logic [3:0] be_n);
        for (int k = 0; k < 4; k++)
            if (!be_n[k] && a[8*k +: 8] != b[8*k +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_step();
        bit arm = (mcnt > 0) && mdone;
        bit expd = arm && (mtmr == 0);
        bit pop = 0, push = 0, nd = 0, any_ca = 0;
        e_rv = 0; e_rd = 0; e_rs = 0; e_serr = 0; e_err = 0;
        for (int i = 0; i < mcnt; i++)
            if (mq[i].cmd == req_cmd && mq[i].addr == req_addr) any_ca = 1;
        if (req_valid) begin
            e_rv = 1;
            if (arm && mq[0].cmd == req_cmd && mq[0].addr == req_addr &&
                mq[0].be_n == req_be_n && bytes_agree(mq[0].data, req_data, req_be_n)) begin
                e_rd = 1; e_rs = req_multi; pop = 1;
            end else if (!any_ca && mcnt < DEPTH) push = 1;
        end
        if (!pop) begin
            if (expd) begin pop = 1; e_serr = serr_en; end
            else if (cpl_valid && mcnt > 0 && !mdone) begin
                if (cpl_err) begin pop = 1; e_err = 1; end
                else nd = 1;
            end
        end
        if (!arm) mtmr = int'(discard_init);
        else if (mtmr != 0) mtmr--;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            mcnt--; mdone = 0;
        end
        if (push) begin
            mq[mcnt] = '{cmd: req_cmd, addr: req_addr, data: req_data,
                         be_n: req_be_n, par: req_par};
            mcnt++;
        end
        if (nd) mdone = 1;
    endtask

    task automatic compare(string tag);
        check(tag, "rsp_valid", rsp_valid, e_rv);
        check(tag, "rsp_done", rsp_done, e_rd);
        check(tag, "rsp_stop", rsp_stop, e_rs);
        check(tag, "sys_err", sys_err, e_serr);
        check(tag, "err_flag", err_flag, e_err);
        check(tag, "q_full", q_full, mcnt == DEPTH);
        check(tag, "fwd_valid", fwd_valid, (mcnt > 0) && !mdone);
        if (mcnt > 0 && !mdone) begin
            check(tag, "fwd_addr", fwd_addr, mq[0].addr);
            check(tag, "fwd_data", fwd_data, mq[0].data);
            check(tag, "fwd_cmd", fwd_cmd, mq[0].cmd);
            check(tag, "fwd_be_n", fwd_be_n, mq[0].be_n);
        end
    endtask

    task automatic step(string tag, bit rv, logic [3:0] cmd, logic [31:0] addr,
                        logic [31:0] data, logic [3:0] be, bit multi, bit cv, bit ce);
        req_valid = rv; req_cmd = cmd; req_addr = addr; req_data = data;
        req_be_n = be; req_par = ^data; req_multi = multi;
        cpl_valid = cv; cpl_err = ce;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 4'h0, 32'h0, 32'h0, 4'h0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        discard_init = 16'd3;
        serr_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "rsp_valid", rsp_valid, 0);
        check("R1", "fwd_valid", fwd_valid, 0);
        check("R1", "q_full", q_full, 0);
        check("R1", "sys_err", sys_err, 0);
        check("R1", "err_flag", err_flag, 0);
        idle("R1", 1);

        step("R2", 1, 4'h7, 32'h100, 32'h11223344, 4'b0100, 0, 0, 0);
        step("R3", 1, 4'h7, 32'h100, 32'h11223344, 4'b0100, 0, 0, 0);
        step("R2", 1, 4'h7, 32'h104, 32'hAAAA0001, 4'b0000, 0, 0, 0);
        step("R2", 1, 4'hB, 32'h108, 32'hBBBB0002, 4'b0000, 0, 0, 0);
        step("R2", 1, 4'h7, 32'h10C, 32'hCCCC0003, 4'b0000, 0, 0, 0);
        step("R4", 1, 4'h7, 32'h110, 32'hDDDD0004, 4'b0000, 0, 0, 0);
        step("R4", 1, 4'h7, 32'h114, 32'hEEEE0005, 4'b0000, 0, 0, 0);
        step("R5", 0, 4'h0, 32'h0, 32'h0, 4'h0, 0, 1, 0);
        step("R7", 1, 4'h7, 32'h100, 32'h11223345, 4'b0100, 0, 0, 0);
        step("R7", 1, 4'h7, 32'h100, 32'h11223344, 4'b0000, 0, 0, 0);
        step("R11", 1, 4'h7, 32'h100, 32'h11FF3344, 4'b0100, 1, 0, 0);
        // R8 discard with error enabled
        step("R8", 0, 4'h0, 32'h0, 32'h0, 4'h0, 0, 1, 0);
        idle("R8", 6);
        // R10 repeat lands on expiry cycle
        step("R10", 0, 4'h0, 32'h0, 32'h0, 4'h0, 0, 1, 0);
        idle("R10", 3);
        step("R10", 1, 4'hB, 32'h108, 32'hBBBB0002, 4'b0000, 0, 0, 0);
        // R10 repeat in the completion cycle
        step("R10", 1, 4'h7, 32'h10C, 32'hCCCC0003, 4'b0000, 0, 1, 0);
        serr_en = 1'b0;
        idle("R8", 6);
        serr_en = 1'b1;
        step("R9", 1, 4'h7, 32'h120, 32'h12345678, 4'b0000, 0, 0, 0);
        step("R9", 0, 4'h0, 32'h0, 32'h0, 4'h0, 0, 1, 1);
        idle("R9", 2);

        // random mix: R2/R3/R6/R8 under load
        for (int n = 0; n < 4000; n++) begin
            bit rv = ($urandom % 3) != 0;
            logic [3:0] cmd = ($urandom % 2) ? 4'h7 : 4'hB;
            logic [31:0] addr = 32'h1000 + 32'(4 * ($urandom % 5));
            logic [31:0] data = ($urandom % 2) ? 32'h11223344 : 32'h11AA3344;
            logic [3:0] be = ($urandom % 3 == 0) ? 4'b0100 : 4'b0000;
            bit cv = ($urandom % 4) == 0;
            bit ce = ($urandom % 5) == 0;
            if ($urandom % 200 == 0) discard_init = 16'($urandom % 6);
            if ($urandom % 100 == 0) serr_en = ~serr_en;
            step("R6 random", rv, cmd, addr, data, be, $urandom % 2, cv, ce);
        end
        finish_run();
    end
endmodule